// File: doc/BRIEF.md
# Priority Interrupt Controller with Nested Service

The controller gathers a set of interrupt request lines, remembers each new request as pending, and offers the processor a single request signal together with the index of the line it should service. The processor takes an interrupt by pulsing an acknowledge input. It reports completion of a handler by pulsing an end-of-service input. Line 0 has the highest priority, and higher indices have lower priority.

A mode input selects one of two service disciplines at run time. In sequential mode, nothing further is offered while any handler is in service, and queued requests are served one at a time, best priority first. In nested mode, a request of strictly better priority than the current service level is offered at once and may preempt the running handler. The in-service mask works as a stack ordered by priority. When the preempting handler ends, the preempted level becomes the current level again. The in-service mask is visible on an output.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the pending and in-service state is empty, `cpu_req_o` is low, `vector_o` is 0 and `in_service_o` is 0.
- R2: A low-to-high transition on a request line sets that line's pending bit at the next clock edge. A line that stays high does not set its pending bit again.
- R3: `cpu_req_o` is high exactly when some pending line is eligible. `vector_o` is the lowest eligible pending index while `cpu_req_o` is high, and 0 otherwise.
- R4: When `ack_i` is high and `cpu_req_o` is high, the line given by `vector_o` leaves the pending set, and its bit in `in_service_o` (bit i = line i) is set at that clock edge.
- R5: When `ack_i` is high and `cpu_req_o` is low, the pending state and the in-service state do not change.
- R6: With `nest_mode_i` low, no line is eligible while `in_service_o` is nonzero. Requests that arrive in that time stay pending.
- R7: With `nest_mode_i` low, once the in-service mask is empty, queued requests are offered one at a time, lowest index first.
- R8: With `nest_mode_i` high and a handler in service, a pending line whose index is strictly below the lowest set in-service bit is eligible.
- R9: With `nest_mode_i` high, a pending line whose index is equal to or above the lowest set in-service bit is not offered.
- R10: An `eoi_i` pulse clears the lowest-index set bit of `in_service_o`. The next lower-priority level then becomes the current level again.
- R11: When `ack_i` and `eoi_i` coincide, end-of-service acts on the mask as it stood before that edge, and the newly acknowledged bit stays set.
- R12: A rising edge on a line in the same cycle that this line is acknowledged leaves the line pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | LINES | Request lines, bit 0 has the highest priority |
| nest_mode_i | input | 1 | 1 selects nested service, 0 selects sequential service |
| ack_i | input | 1 | Processor acknowledge, one cycle per interrupt taken |
| eoi_i | input | 1 | End of service for the current level |
| cpu_req_o | output | 1 | Request to the processor |
| vector_o | output | VW | Index of the line being offered |
| in_service_o | output | LINES | Mask of lines currently in service |

## Verification
Acknowledge and end-of-service can fall in the same clock cycle in nested mode. This happens when a better-priority line preempts a handler just as that handler finishes. The bench provokes it by raising line 0 while line 4 is in service, then pulsing both strobes in the same cycle. It judges the result by requiring the in-service mask to read exactly bit 0 afterwards: line 4 is retired and line 0 is kept. A second collision, a fresh edge on a line in the cycle it is acknowledged, is judged by the line being offered again after its handler ends.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned LINES = 8,
  localparam int unsigned VW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_i,
  input  logic             nest_mode_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             cpu_req_o,
  output logic [VW-1:0]    vector_o,
  output logic [LINES-1:0] in_service_o
);

  function automatic logic [VW-1:0] first_set(input logic [LINES-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) r = VW'(i);
    return r;
  endfunction

  logic [LINES-1:0] irq_q, pend_q, isr_q;
  logic [LINES-1:0] allow;

  wire [LINES-1:0] rise = irq_i & ~irq_q;
  wire             busy = |isr_q;
  wire [VW-1:0]    top  = first_set(isr_q);

  always_comb begin
    if (!busy)            allow = '1;
    else if (nest_mode_i) allow = (LINES'(1) << top) - LINES'(1);
    else                  allow = '0;
  end

  wire [LINES-1:0] cand = pend_q & allow;

  assign cpu_req_o    = |cand;
  assign vector_o     = cpu_req_o ? first_set(cand) : '0;
  assign in_service_o = isr_q;

  wire             take     = ack_i & cpu_req_o;
  wire [LINES-1:0] take_bit = take ? (LINES'(1) << vector_o) : '0;
  wire [LINES-1:0] done_bit = (eoi_i & busy) ? (LINES'(1) << top) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= (pend_q & ~take_bit) | rise;
      isr_q  <= (isr_q & ~done_bit) | take_bit;
    end
  end

  p_seq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_mode_i && |in_service_o) |-> !cpu_req_o);

  p_ack_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && cpu_req_o) |=> in_service_o[$past(vector_o)]);

  p_ack_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !cpu_req_o && !eoi_i) |=> in_service_o == $past(in_service_o));

  p_nest_rank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_o && |in_service_o) |-> (vector_o < first_set(in_service_o)));

  p_eoi_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_i && |in_service_o) |=>
      ($countones(in_service_o) + 1 == $countones($past(in_service_o))));

endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] irq_i = '0;
  logic       nest_mode_i = 0, ack_i = 0, eoi_i = 0;
  logic       cpu_req_o;
  logic [2:0] vector_o;
  logic [7:0] in_service_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.LINES(8)) dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nest_mode_i(nest_mode_i),
    .ack_i(ack_i), .eoi_i(eoi_i), .cpu_req_o(cpu_req_o),
    .vector_o(vector_o), .in_service_o(in_service_o));

  // {irq, nest, ack, eoi, exp_req, exp_vec, exp_isr}
  localparam int ROWS = 19;
  localparam logic [22:0] TBL [ROWS] = '{
    {8'h04, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 8'h00}, // R2 R3
    {8'h24, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h04}, // R4 R6
    {8'h25, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h04}, // R6
    {8'h25, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h00}, // R7 R10
    {8'h25, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h01}, // R4 R6
    {8'h25, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 8'h00}, // R7
    {8'h25, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h20}, // R4
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 8'h00}, // R10
    {8'h08, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3, 8'h00}, // R3
    {8'h08, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h08}, // R4
    {8'h18, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h08}, // R9
    {8'h1A, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 8'h08}, // R8
    {8'h1A, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h0A}, // R4 R9
    {8'h1A, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 8'h08}, // R10 R9
    {8'h1A, 1'b1, 1'b0, 1'b1, 1'b1, 3'd4, 8'h00}, // R10
    {8'h1A, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h10}, // R4
    {8'h1B, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 8'h10}, // R8
    {8'h1B, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 8'h01}, // R11
    {8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 8'h00}  // R10
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [7:0] irq, input logic nm, input logic a, input logic e);
    irq_i = irq; nest_mode_i = nm; ack_i = a; eoi_i = e;
    @(negedge clk);
  endtask

  task automatic expect3(input string tag, input logic r, input logic [2:0] v, input logic [7:0] m);
    chk({tag, " req"}, cpu_req_o, r);
    chk({tag, " vec"}, vector_o, v);
    chk({tag, " isr"}, in_service_o, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect3("R1 in reset", 0, 0, 8'h00);
    rst_n = 1;
    @(negedge clk);
    expect3("R1 after reset", 0, 0, 8'h00);

    for (int i = 0; i < ROWS; i++) begin
      step(TBL[i][22:15], TBL[i][14], TBL[i][13], TBL[i][12]);
      expect3($sformatf("table row %0d (R2..R11 per row tag)", i),
              TBL[i][11], TBL[i][10:8], TBL[i][7:0]);
    end

    // R5: acknowledge with no request offered
    step(8'h00, 1, 1, 0);
    expect3("R5 idle ack", 0, 0, 8'h00);
    step(8'h80, 1, 0, 0);
    expect3("R5 later request still served", 1, 7, 8'h00);
    step(8'h00, 1, 1, 0);
    step(8'h00, 1, 0, 1);
    expect3("R5 cleanup", 0, 0, 8'h00);

    // R12: a new edge coinciding with the acknowledge of that line
    step(8'h40, 1, 0, 0);
    expect3("R12 first edge", 1, 6, 8'h00);
    step(8'h00, 1, 0, 0);
    step(8'h40, 1, 1, 0);
    expect3("R12 ack with edge", 0, 0, 8'h40);
    step(8'h40, 1, 0, 1);
    expect3("R12 still pending", 1, 6, 8'h00);
    step(8'h40, 1, 1, 0);
    expect3("R2 held level taken", 0, 0, 8'h40);
    step(8'h40, 1, 0, 1);
    expect3("R2 held level not relatched", 0, 0, 8'h00);

    // R1: reset mid-service
    step(8'h01, 1, 0, 0);
    step(8'h01, 1, 1, 0);
    expect3("R1 pre-reset service", 0, 0, 8'h01);
    rst_n = 0;
    @(negedge clk);
    expect3("R1 mid-run reset", 0, 0, 8'h00);
    rst_n = 1;
    step(8'h00, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule